// File: doc/BRIEF.md
# Edge-Interrupt GPIO Port

This block is an eight-pin general-purpose I/O port behind a small synchronous register port. Each pin can be an input or an output. An output pin drives the value held in the data register. An input pin is read back through a two-stage synchronizer. All pins share one interrupt line.

Any input transition can be latched as a pending interrupt. Rising and falling transitions each have their own per-pin enable. A per-pin interrupt enable decides whether an edge latches at all, and it also gates the pin's pending bit onto the shared line. Software acknowledges pins by writing a mask to a dedicated end-of-interrupt register. Writing the status register has no effect.

Register offsets, with bit n of each register belonging to pin n:

- data: 0
- interrupt enable: 1
- pending status: 2
- end-of-interrupt: 3
- rising enable: 4
- falling enable: 5
- direction: 6

Top module: `gpio_edge_irq_port`

## Requirements
- R1: After reset, every register reads 0, every pin is an input (`pin_oe` = 0) and `irq` is low.
- R2: A read of offset 0 returns, for each pin, the written data bit if the pin is an output, or the pin level seen through the two-flop synchronizer if it is an input. `pin_out` always carries the written data bits.
- R3: Offset 6 is the direction register (bit value 1 = output, 0 = input). `pin_oe` equals it and changes only on a write to offset 6.
- R4: A 0-to-1 change on a pin whose rising enable (offset 4) and interrupt enable (offset 1) bits are set makes its status bit (offset 2) read 1. The bit is set by the third rising clock edge after the pin changes.
- R5: A 1-to-0 change latches in the same way under the falling enable (offset 5). With both edge enables set, either direction latches.
- R6: An edge on a pin whose interrupt enable is clear, or whose matching edge enable is clear, leaves its status bit at 0.
- R7: Writing a mask to offset 3 clears exactly the status bits set in the mask and leaves the others. Offset 3 always reads 0.
- R8: `irq` is high while any pin has both its status bit and its interrupt enable bit set. Clearing an enable bit masks the pin but keeps its status bit. Setting the enable bit again raises `irq` again.
- R9: If a new edge and an end-of-interrupt clear hit the same bit in the same cycle, the bit stays pending.
- R10: Reading status does not change it. Writes to offset 2 are ignored. Offset 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| pin_in | input | 8 | Pin levels from the pads |
| pin_out | output | 8 | Output values to the pads |
| pin_oe | output | 8 | Per-pin output enable |
| irq | output | 1 | Shared interrupt request |

## Verification
The hardest case to reach from the ports is the collision in R9. A new edge and an end-of-interrupt write must land on the same status bit in the same clock cycle. The bench first makes the bit pending through one edge direction. It then changes the pin the other way at a known negative edge, counts the two synchronizer stages, and places the acknowledge write so that it commits on the very clock that latches the new edge. The bench also checks that masking keeps a pending bit while dropping `irq`.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int unsigned REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    RA_DATA = 3'd0,
    RA_IEN  = 3'd1,
    RA_STAT = 3'd2,
    RA_EOI  = 3'd3,
    RA_RISE = 3'd4,
    RA_FALL = 3'd5,
    RA_DIR  = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (g == 0) begin : g_first
      assign stage_d = din;
    end else begin : g_rest
      assign stage_d = stage_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= stage_d;
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;
  end

  assign rise = level & ~prev_q;
  assign fall = ~level & prev_q;

  // R4
  rise_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((rise & $past(rise)) == '0));

  // R5
  fall_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|fall) |=> ((fall & $past(fall)) == '0));
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] rise,
  input  logic [WIDTH-1:0] fall,
  input  logic [WIDTH-1:0] rise_en,
  input  logic [WIDTH-1:0] fall_en,
  input  logic [WIDTH-1:0] int_en,
  input  logic [WIDTH-1:0] eoi_mask,
  output logic [WIDTH-1:0] status,
  output logic             irq
);
  logic [WIDTH-1:0] edge_hit;
  logic [WIDTH-1:0] status_d;
  logic [WIDTH-1:0] status_q;

  always_comb begin
    edge_hit = ((rise & rise_en) | (fall & fall_en)) & int_en;
    // A new edge wins over a clear in the same cycle.
    status_d = (status_q & ~eoi_mask) | edge_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  assign status = status_q;
  assign irq    = |(status_q & int_en);

  // R7
  eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(eoi_mask & ~edge_hit)) |=> ((status_q & $past(eoi_mask & ~edge_hit)) == '0));

  // R9
  edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_hit) |=> ((status_q & $past(edge_hit)) == $past(edge_hit)));

  // R6
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(edge_hit)) == '0));
endmodule

// File: rtl/gpio_edge_irq_port.sv
module gpio_edge_irq_port
  import gpio_edge_pkg::*;
#(
  parameter int unsigned PINS        = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [PINS-1:0]       wdata,
  output logic [PINS-1:0]       rdata,
  input  logic [PINS-1:0]       pin_in,
  output logic [PINS-1:0]       pin_out,
  output logic [PINS-1:0]       pin_oe,
  output logic                  irq
);
  logic [PINS-1:0] data_q, ien_q, rise_q, fall_q, dir_q;
  logic [PINS-1:0] data_d, ien_d, rise_d, fall_d, dir_d;
  logic            data_we, ien_we, rise_we, fall_we, dir_we;
  logic [PINS-1:0] eoi_mask;
  logic [PINS-1:0] pin_sync, pin_rise, pin_fall, status;

  gpio_pin_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(pin_sync)
  );

  gpio_edge_detect #(.WIDTH(PINS)) u_edge (
    .clk(clk), .rst_n(rst_n), .level(pin_sync), .rise(pin_rise), .fall(pin_fall)
  );

  gpio_irq_status #(.WIDTH(PINS)) u_stat (
    .clk(clk), .rst_n(rst_n), .rise(pin_rise), .fall(pin_fall),
    .rise_en(rise_q), .fall_en(fall_q), .int_en(ien_q),
    .eoi_mask(eoi_mask), .status(status), .irq(irq)
  );

  // Write decode and next state
  always_comb begin
    data_we  = wr_en && (addr == RA_DATA);
    ien_we   = wr_en && (addr == RA_IEN);
    rise_we  = wr_en && (addr == RA_RISE);
    fall_we  = wr_en && (addr == RA_FALL);
    dir_we   = wr_en && (addr == RA_DIR);
    eoi_mask = (wr_en && (addr == RA_EOI)) ? wdata : '0;
    data_d   = data_we ? wdata : data_q;
    ien_d    = ien_we  ? wdata : ien_q;
    rise_d   = rise_we ? wdata : rise_q;
    fall_d   = fall_we ? wdata : fall_q;
    dir_d    = dir_we  ? wdata : dir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ien_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      dir_q  <= '0;
    end else begin
      data_q <= data_d;
      ien_q  <= ien_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
      dir_q  <= dir_d;
    end
  end

  // Read mux
  always_comb begin
    case (addr)
      RA_DATA: rdata = (data_q & dir_q) | (pin_sync & ~dir_q);
      RA_IEN:  rdata = ien_q;
      RA_STAT: rdata = status;
      RA_RISE: rdata = rise_q;
      RA_FALL: rdata = fall_q;
      RA_DIR:  rdata = dir_q;
      default: rdata = '0;
    endcase
  end

  assign pin_out = data_q;
  assign pin_oe  = dir_q;

  // R3
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == RA_DIR)) |=> $stable(pin_oe));
endmodule

// File: tb/gpio_edge_irq_port_test.sv
module gpio_edge_irq_port_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [2:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic [7:0] pin_in;
  logic [7:0] pin_out;
  logic [7:0] pin_oe;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  gpio_edge_irq_port uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // {offset, write value, expected read-back}
  localparam logic [23:0] VEC [7] = '{
    {8'd1, 8'hA5, 8'hA5},
    {8'd4, 8'h3C, 8'h3C},
    {8'd5, 8'hC3, 8'hC3},
    {8'd6, 8'h0F, 8'h0F},
    {8'd3, 8'hFF, 8'h00},
    {8'd2, 8'hFF, 8'h00},
    {8'd7, 8'h5A, 8'h00}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic drive_pins(input logic [7:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), r);
      check("R1 reg after reset", r, 8'h00);
    end
    check("R1 pin_oe", pin_oe, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);

    // Register table: R3 direction, R7 EOI reads 0, R10 status/unused
    for (int i = 0; i < 7; i++) begin
      wr(VEC[i][18:16], VEC[i][15:8]);
      rd(VEC[i][18:16], r);
      check("R3/R7/R10 table read-back", r, VEC[i][7:0]);
    end
    wr(3'd1, 8'h00); wr(3'd4, 8'h00); wr(3'd5, 8'h00);
    check("R3 pin_oe follows direction", pin_oe, 8'h0F);

    // R2 mixed data read
    wr(3'd0, 8'h36);
    drive_pins(8'hA0);
    rd(3'd0, r);
    check("R2 data read mix", r, 8'hA6);
    check("R2 pin_out", pin_out, 8'h36);
    wr(3'd6, 8'h00);
    drive_pins(8'h00);
    check("R3 pin_oe cleared", pin_oe, 8'h00);

    // R4 / R5 / R7 edges and selective acknowledge
    wr(3'd1, 8'hFF); wr(3'd4, 8'h05); wr(3'd5, 8'h06);
    drive_pins(8'h07);
    rd(3'd2, r);
    check("R4 rising latch", r, 8'h05);
    check("R8 irq on pending", {7'd0, irq}, 8'h01);
    wr(3'd3, 8'h05);
    rd(3'd2, r);
    check("R7 eoi clears", r, 8'h00);
    check("R8 irq off", {7'd0, irq}, 8'h00);
    drive_pins(8'h00);
    rd(3'd2, r);
    check("R5 falling latch", r, 8'h06);
    wr(3'd3, 8'h02);
    rd(3'd2, r);
    check("R7 selective clear", r, 8'h04);
    wr(3'd3, 8'hFF);

    // R6 disabled edges ignored
    wr(3'd1, 8'hEF); wr(3'd4, 8'h10); wr(3'd5, 8'h00);
    drive_pins(8'h30);
    rd(3'd2, r);
    check("R6 no latch", r, 8'h00);
    check("R6 irq low", {7'd0, irq}, 8'h00);
    drive_pins(8'h00);

    // R8 masking and R10 status side effects
    wr(3'd1, 8'hFF); wr(3'd4, 8'h80);
    drive_pins(8'h80);
    rd(3'd2, r);
    check("R8 pending bit7", r, 8'h80);
    wr(3'd2, 8'h00);
    rd(3'd2, r);
    check("R10 status write ignored", r, 8'h80);
    rd(3'd2, r);
    check("R10 reread stable", r, 8'h80);
    wr(3'd1, 8'h7F);
    check("R8 masked irq", {7'd0, irq}, 8'h00);
    rd(3'd2, r);
    check("R8 status kept while masked", r, 8'h80);
    wr(3'd1, 8'hFF);
    check("R8 unmask reasserts", {7'd0, irq}, 8'h01);
    wr(3'd3, 8'h80);
    check("R8 irq after eoi", {7'd0, irq}, 8'h00);
    drive_pins(8'h00);

    // R9 collision of edge and acknowledge
    wr(3'd4, 8'h08); wr(3'd5, 8'h08);
    drive_pins(8'h08);
    rd(3'd2, r);
    check("R9 setup pending", r, 8'h08);
    @(negedge clk); pin_in = 8'h00;   // N0
    @(negedge clk);                   // N1, second stage captures next edge
    wr(3'd3, 8'h08);                  // commits on the latching edge
    rd(3'd2, r);
    check("R9 edge wins over eoi", r, 8'h08);
    wr(3'd3, 8'h08);
    rd(3'd2, r);
    check("R7 final clear", r, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule